// File: doc/BRIEF.md
# Single-Cycle 32-bit Load/Store Processor Core

This block is a small 32-bit processor that completes one instruction every clock cycle. On each cycle it presents the program counter on an instruction port and decodes the returned word. It reads two operands from a 32-entry register file and computes a result. In the same cycle it either writes the result back, accesses a word-wide data port, or redirects the program counter. Both memories sit outside the block. The instruction port and the data read port are combinational: data returns in the same cycle. A data write is taken on the rising clock edge while the write strobe is high.

The core executes a fixed set of twelve instructions in three formats. The register format covers add, sub, slt and jr. The immediate format covers addi, slti, lw, sw, beq and bne. The jump format covers j and jal. A load or store whose byte address is not a multiple of four does not reach memory. It raises a flag for the cycle in which it executes and has no other effect, and execution continues with the next word. Any instruction outside the set has no effect other than advancing the program counter.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0x00400000 and clears every register to zero.
- R2: With opcode bits [31:26] equal to 0, funct bits [5:0] equal to 32 (add) or 34 (sub) write the sum or difference of registers rs[25:21] and rt[20:16] into register rd[15:11], modulo 2^32.
- R3: slt (opcode 0, funct 42) and slti (opcode 10) compare their two operands as signed numbers and write 1 if the first is less and 0 otherwise. slt writes rd and slti writes rt.
- R4: addi (opcode 8) adds rs to the 16-bit immediate in bits [15:0], sign-extended, and writes the result into rt.
- R5: Register 0 reads as zero, and writes that target it are discarded.
- R6: lw (opcode 35) and sw (opcode 43) use the byte address rs plus the sign-extended 16-bit offset. lw writes the returned word into rt, and sw drives rt on the write data with the write strobe high.
- R7: beq (opcode 4) when rs equals rt, and bne (opcode 5) when they differ, set the PC to PC+4 plus the sign-extended offset shifted left by 2. In all other cases the PC becomes PC+4.
- R8: j (opcode 2) and jal (opcode 3) jump to a target made of PC+4 bits [31:28], the 26-bit field [25:0], and two zero bits. jal also writes PC+4 into register 31.
- R9: jr (opcode 0, funct 8) loads the PC from register rs with its two low bits cleared.
- R10: A lw or sw whose address has either of its two low bits set raises the misalign output for that cycle. Such an access writes neither memory nor any register, and the PC advances by 4.
- R11: An opcode or register-format funct outside the set above writes nothing and advances the PC by 4.
- R12: The two low bits of the PC are zero at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Byte address of the instruction being executed (the PC) |
| imem_data | input | 32 | Instruction word at imem_addr, valid in the same cycle |
| dmem_addr | output | 32 | Byte address of the data access |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, taken on the rising clock edge |
| dmem_re | output | 1 | High while an aligned load is executing |
| dmem_rdata | input | 32 | Load data for dmem_addr, valid in the same cycle |
| misalign | output | 1 | High for a cycle that executes a misaligned lw or sw |

## Verification
The assertions assume that imem_data and dmem_rdata settle within the cycle for the address presented. They also assume that the environment never changes the program counter's word except through the core's own control flow. The bench meets this by modelling both memories as arrays read combinationally and by loading each program only while reset is held. Programs keep every data address inside the modelled data array and end on a jump to themselves, so the core never runs past the loaded code. Register values are observed only by storing them to data memory, and every stored word is predicted arithmetically from the operand sweep.

// File: rtl/sc_core_pkg.sv
package sc_core_pkg;

    localparam int XLEN     = 32;
    localparam int NREGS    = 32;
    localparam int RIDX_W   = $clog2(NREGS);
    localparam logic [XLEN-1:0] RESET_PC = 32'h0040_0000;
    localparam logic [RIDX_W-1:0] LINK_REG = RIDX_W'(NREGS - 1);

    localparam logic [5:0] OP_REG  = 6'd0;
    localparam logic [5:0] OP_J    = 6'd2;
    localparam logic [5:0] OP_JAL  = 6'd3;
    localparam logic [5:0] OP_BEQ  = 6'd4;
    localparam logic [5:0] OP_BNE  = 6'd5;
    localparam logic [5:0] OP_ADDI = 6'd8;
    localparam logic [5:0] OP_SLTI = 6'd10;
    localparam logic [5:0] OP_LW   = 6'd35;
    localparam logic [5:0] OP_SW   = 6'd43;

    localparam logic [5:0] FN_JR   = 6'd8;
    localparam logic [5:0] FN_ADD  = 6'd32;
    localparam logic [5:0] FN_SUB  = 6'd34;
    localparam logic [5:0] FN_SLT  = 6'd42;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_SLT} alu_op_e;
    typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_LINK} wb_sel_e;

    typedef struct packed {
        alu_op_e           alu;
        logic              use_imm;
        logic              reg_we;
        wb_sel_e           wb;
        logic [RIDX_W-1:0] dst;
        logic              is_load;
        logic              is_store;
        logic              is_beq;
        logic              is_bne;
        logic              is_jump;
        logic              is_jr;
        logic              illegal;
    } ctrl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

endpackage

// File: rtl/sc_core_decode.sv
module sc_core_decode
    import sc_core_pkg::*;
(
    input  logic [5:0]        op,
    input  logic [5:0]        funct,
    input  logic [RIDX_W-1:0] rt,
    input  logic [RIDX_W-1:0] rd,
    output ctrl_t             ctrl
);

    always_comb begin
        ctrl.alu      = ALU_ADD;
        ctrl.use_imm  = 1'b0;
        ctrl.reg_we   = 1'b0;
        ctrl.wb       = WB_ALU;
        ctrl.dst      = rd;
        ctrl.is_load  = 1'b0;
        ctrl.is_store = 1'b0;
        ctrl.is_beq   = 1'b0;
        ctrl.is_bne   = 1'b0;
        ctrl.is_jump  = 1'b0;
        ctrl.is_jr    = 1'b0;
        ctrl.illegal  = 1'b0;
        unique case (op)
            OP_REG: begin
                unique case (funct)
                    FN_ADD: ctrl.reg_we = 1'b1;
                    FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.alu = ALU_SUB; end
                    FN_SLT: begin ctrl.reg_we = 1'b1; ctrl.alu = ALU_SLT; end
                    FN_JR:  ctrl.is_jr = 1'b1;
                    default: ctrl.illegal = 1'b1;
                endcase
            end
            OP_ADDI: begin
                ctrl.use_imm = 1'b1; ctrl.reg_we = 1'b1; ctrl.dst = rt;
            end
            OP_SLTI: begin
                ctrl.use_imm = 1'b1; ctrl.reg_we = 1'b1; ctrl.dst = rt;
                ctrl.alu = ALU_SLT;
            end
            OP_LW: begin
                ctrl.use_imm = 1'b1; ctrl.reg_we = 1'b1; ctrl.dst = rt;
                ctrl.wb = WB_MEM; ctrl.is_load = 1'b1;
            end
            OP_SW: begin
                ctrl.use_imm = 1'b1; ctrl.is_store = 1'b1;
            end
            OP_BEQ: ctrl.is_beq = 1'b1;
            OP_BNE: ctrl.is_bne = 1'b1;
            OP_J:   ctrl.is_jump = 1'b1;
            OP_JAL: begin
                ctrl.is_jump = 1'b1; ctrl.reg_we = 1'b1;
                ctrl.wb = WB_LINK; ctrl.dst = LINK_REG;
            end
            default: ctrl.illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/sc_core_regfile.sv
module sc_core_regfile #(
    parameter int W     = 32,
    parameter int N     = 32,
    parameter int NREAD = 2,
    localparam int AW   = $clog2(N)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NREAD-1:0][AW-1:0] raddr,
    output logic [NREAD-1:0][W-1:0]  rdata,
    input  logic                we,
    input  logic [AW-1:0]       waddr,
    input  logic [W-1:0]        wdata
);

    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NREAD; g++) begin : g_rd
        assign rdata[g] = (raddr[g] == '0) ? '0 : regs[raddr[g]];
    end

    // R5: a write aimed at register 0 leaves it reading zero
    a_r5_zero_reg_ignored: assert property (@(posedge clk) disable iff (rst)
        (we && waddr == '0) |=> (regs[0] == '0));

endmodule

// File: rtl/sc_core_alu.sv
module sc_core_alu
    import sc_core_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    always_comb begin
        unique case (op)
            ALU_SUB: y = a - b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : '0;
            default: y = a + b;
        endcase
    end

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_core_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_data,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    output logic        dmem_re,
    input  logic [31:0] dmem_rdata,
    output logic        misalign
);

    logic [XLEN-1:0] pc, pc_next, pc_plus4, br_target, jmp_target, jr_target;
    logic [XLEN-1:0] imm, alu_b, alu_y, wb_data;
    logic [1:0][RIDX_W-1:0] raddr;
    logic [1:0][XLEN-1:0]   rdata;
    logic [XLEN-1:0] rs_val, rt_val;
    logic            rf_we, take_branch;
    ctrl_t           ctrl;

    assign imem_addr = pc;
    assign raddr[0]  = imem_data[25:21];
    assign raddr[1]  = imem_data[20:16];
    assign rs_val    = rdata[0];
    assign rt_val    = rdata[1];
    assign imm       = sext16(imem_data[15:0]);

    sc_core_decode u_decode (
        .op    (imem_data[31:26]),
        .funct (imem_data[5:0]),
        .rt    (imem_data[20:16]),
        .rd    (imem_data[15:11]),
        .ctrl  (ctrl)
    );

    sc_core_regfile #(.W(XLEN), .N(NREGS), .NREAD(2)) u_regfile (
        .clk   (clk),
        .rst   (rst),
        .raddr (raddr),
        .rdata (rdata),
        .we    (rf_we),
        .waddr (ctrl.dst),
        .wdata (wb_data)
    );

    assign alu_b = ctrl.use_imm ? imm : rt_val;

    sc_core_alu #(.W(XLEN)) u_alu (
        .op (ctrl.alu),
        .a  (rs_val),
        .b  (alu_b),
        .y  (alu_y)
    );

    // data side
    assign misalign   = (ctrl.is_load || ctrl.is_store) && (alu_y[1:0] != 2'b00);
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = ctrl.is_store && !misalign;
    assign dmem_re    = ctrl.is_load && !misalign;

    // write-back
    assign rf_we = ctrl.reg_we && !(ctrl.is_load && misalign);
    always_comb begin
        unique case (ctrl.wb)
            WB_MEM:  wb_data = dmem_rdata;
            WB_LINK: wb_data = pc_plus4;
            default: wb_data = alu_y;
        endcase
    end

    // next PC
    assign pc_plus4    = pc + XLEN'(4);
    assign br_target   = pc_plus4 + {imm[XLEN-3:0], 2'b00};
    assign jmp_target  = {pc_plus4[31:28], imem_data[25:0], 2'b00};
    assign jr_target   = {rs_val[XLEN-1:2], 2'b00};
    assign take_branch = (ctrl.is_beq && rs_val == rt_val) ||
                         (ctrl.is_bne && rs_val != rt_val);

    always_comb begin
        if (ctrl.is_jump)      pc_next = jmp_target;
        else if (ctrl.is_jr)   pc_next = jr_target;
        else if (take_branch)  pc_next = br_target;
        else                   pc_next = pc_plus4;
    end

    always_ff @(posedge clk) begin
        if (rst) pc <= RESET_PC;
        else     pc <= pc_next;
    end

    // R1: reset vector
    a_r1_reset_pc: assert property (@(posedge clk)
        rst |=> (pc == RESET_PC));
    // R12: program counter stays word aligned
    a_r12_pc_aligned: assert property (@(posedge clk) disable iff (rst)
        (imem_addr[1:0] == 2'b00));
    // R10: a misaligned access touches neither memory nor registers
    a_r10_no_side_effects: assert property (@(posedge clk) disable iff (rst)
        misalign |-> (!dmem_we && !dmem_re && !rf_we));
    // R10: execution continues with the next word after a misaligned access
    a_r10_pc_advance: assert property (@(posedge clk) disable iff (rst)
        misalign |=> (imem_addr == $past(imem_addr) + 32'd4));
    // R11: an undefined encoding writes nothing and falls through
    a_r11_illegal_quiet: assert property (@(posedge clk) disable iff (rst)
        ctrl.illegal |-> (!rf_we && !dmem_we && pc_next == pc_plus4));

endmodule

// File: tb/sc_core_bench.sv
module sc_core_bench;

    localparam logic [31:0] BASE = 32'h0040_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we, dmem_re, misalign;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];

    int tests = 0;
    int fails = 0;
    int mis_cnt = 0;
    int cycles = 0;
    bit done = 0;

    always #10 clk = ~clk;

    assign imem_data  = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];
    always @(posedge clk) if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
    always @(negedge clk) if (!rst && misalign) mis_cnt++;

    sc_core u_sc_core (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
        .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
        .dmem_re(dmem_re), .dmem_rdata(dmem_rdata), .misalign(misalign)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction
    function automatic logic [31:0] enc_j(input logic [5:0] op, input int idx);
        logic [31:0] t;
        t = BASE + 32'(idx * 4);
        return {op, t[27:2]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) begin imem[i] = 32'h0; dmem[i] = 32'h0; end
    endtask

    task automatic run(input int n);
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        mis_cnt = 0;
        rst = 1'b0;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    logic [31:0] vals [8];
    int imms [5];

    initial begin
        vals[0] = 32'h0;        vals[1] = 32'h1;        vals[2] = 32'hFFFF_FFFF;
        vals[3] = 32'h7FFF_FFFF; vals[4] = 32'h8000_0000; vals[5] = 32'd5;
        vals[6] = 32'hFFFF_FFFB; vals[7] = 32'h0001_2340;
        imms[0] = -1; imms[1] = 0; imms[2] = 1; imms[3] = 32767; imms[4] = -32768;

        // R1: reset vector, then registers cleared by a second reset
        clear_mem();
        imem[0] = enc_i(6'd8, 0, 7, 9);
        imem[1] = enc_j(6'd2, 1);
        run(3);
        clear_mem();
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 reset pc", imem_addr, BASE);
        dmem[10] = 32'hDEAD_BEEF;
        imem[0] = enc_i(6'd43, 0, 7, 40);
        imem[1] = enc_j(6'd2, 1);
        run(3);
        check("R1 regs cleared", dmem[10], 32'h0);

        // R2 R3 R6 R7: operand sweep for register format and branches
        for (int i = 0; i < 8; i++) begin
            for (int j = 0; j < 8; j++) begin
                clear_mem();
                dmem[0] = vals[i]; dmem[1] = vals[j];
                imem[0]  = enc_i(6'd35, 0, 1, 0);
                imem[1]  = enc_i(6'd35, 0, 2, 4);
                imem[2]  = enc_r(6'd32, 1, 2, 3);
                imem[3]  = enc_r(6'd34, 1, 2, 4);
                imem[4]  = enc_r(6'd42, 1, 2, 5);
                imem[5]  = enc_i(6'd43, 0, 3, 8);
                imem[6]  = enc_i(6'd43, 0, 4, 12);
                imem[7]  = enc_i(6'd43, 0, 5, 16);
                imem[8]  = enc_i(6'd4, 1, 2, 1);
                imem[9]  = enc_i(6'd8, 0, 8, 1);
                imem[10] = enc_i(6'd5, 1, 2, 1);
                imem[11] = enc_i(6'd8, 0, 11, 1);
                imem[12] = enc_i(6'd43, 0, 8, 20);
                imem[13] = enc_i(6'd43, 0, 11, 24);
                imem[14] = enc_j(6'd2, 14);
                run(20);
                check("R2 add", dmem[2], vals[i] + vals[j]);
                check("R2 sub", dmem[3], vals[i] - vals[j]);
                check("R3 slt", dmem[4], ($signed(vals[i]) < $signed(vals[j])) ? 32'd1 : 32'd0);
                check("R7 beq", dmem[5], (vals[i] == vals[j]) ? 32'd0 : 32'd1);
                check("R7 bne", dmem[6], (vals[i] != vals[j]) ? 32'd0 : 32'd1);
            end
        end

        // R3 R4: immediate sweep
        for (int i = 0; i < 8; i++) begin
            for (int k = 0; k < 5; k++) begin
                clear_mem();
                dmem[0] = vals[i];
                imem[0] = enc_i(6'd35, 0, 1, 0);
                imem[1] = enc_i(6'd8, 1, 6, imms[k]);
                imem[2] = enc_i(6'd10, 1, 7, imms[k]);
                imem[3] = enc_i(6'd43, 0, 6, 8);
                imem[4] = enc_i(6'd43, 0, 7, 12);
                imem[5] = enc_j(6'd2, 5);
                run(8);
                check("R4 addi", dmem[2], vals[i] + 32'(imms[k]));
                check("R3 slti", dmem[3], ($signed(vals[i]) < imms[k]) ? 32'd1 : 32'd0);
            end
        end

        // R5: register 0
        clear_mem();
        dmem[0] = 32'h0000_AAAA;
        imem[0] = enc_i(6'd8, 0, 0, 5);
        imem[1] = enc_i(6'd35, 0, 0, 0);
        imem[2] = enc_i(6'd43, 0, 0, 8);
        imem[3] = enc_i(6'd8, 0, 2, -7);
        imem[4] = enc_i(6'd43, 0, 2, 12);
        imem[5] = enc_j(6'd2, 5);
        run(8);
        check("R5 r0 stays zero", dmem[2], 32'h0);
        check("R5 r0 source", dmem[3], 32'hFFFF_FFF9);

        // R7: backward branch loop
        for (int n = 1; n <= 5; n++) begin
            clear_mem();
            imem[0] = enc_i(6'd8, 0, 9, 0);
            imem[1] = enc_i(6'd8, 0, 10, n);
            imem[2] = enc_i(6'd8, 9, 9, 3);
            imem[3] = enc_i(6'd8, 10, 10, -1);
            imem[4] = enc_i(6'd5, 10, 0, -3);
            imem[5] = enc_i(6'd43, 0, 9, 24);
            imem[6] = enc_j(6'd2, 6);
            run(30);
            check("R7 loop", dmem[6], 32'(3 * n));
        end

        // R8 R9: jal, link, jr back, j to self
        clear_mem();
        imem[0]  = enc_j(6'd3, 8);
        imem[1]  = enc_i(6'd43, 0, 12, 28);
        imem[2]  = enc_j(6'd2, 2);
        imem[8]  = enc_i(6'd8, 0, 12, 77);
        imem[9]  = enc_i(6'd43, 0, 31, 32);
        imem[10] = enc_r(6'd8, 31, 0, 0);
        run(12);
        check("R8 jal link", dmem[8], BASE + 32'd4);
        check("R9 jr return", dmem[7], 32'd77);
        check("R8 j self", imem_addr, BASE + 32'd8);

        // R9 R12: jr clears low bits
        clear_mem();
        dmem[9]  = BASE + 32'h23;
        imem[0]  = enc_i(6'd35, 0, 20, 36);
        imem[1]  = enc_r(6'd8, 20, 0, 0);
        imem[8]  = enc_i(6'd8, 0, 21, 5);
        imem[9]  = enc_i(6'd43, 0, 21, 40);
        imem[10] = enc_j(6'd2, 10);
        run(8);
        check("R9 jr target", dmem[10], 32'd5);
        check("R12 pc aligned", imem_addr, BASE + 32'h28);

        // R10: misaligned load and store
        clear_mem();
        dmem[1] = 32'h1111_1111;
        imem[0] = enc_i(6'd8, 0, 13, 55);
        imem[1] = enc_i(6'd35, 0, 13, 2);
        imem[2] = enc_i(6'd8, 0, 14, 99);
        imem[3] = enc_i(6'd43, 0, 14, 5);
        imem[4] = enc_i(6'd43, 0, 13, 36);
        imem[5] = enc_j(6'd2, 5);
        run(10);
        check("R10 load no reg write", dmem[9], 32'd55);
        check("R10 store no mem write", dmem[1], 32'h1111_1111);
        check("R10 flag cycles", 32'(mis_cnt), 32'd2);
        check("R10 pc continues", imem_addr, BASE + 32'd20);

        // R11: undefined encodings are no-ops
        clear_mem();
        imem[0] = enc_i(6'd8, 0, 15, 12);
        imem[1] = {6'd63, 5'd0, 5'd15, 16'd1};
        imem[2] = enc_r(6'h3f, 0, 0, 15);
        imem[3] = {6'd1, 5'd0, 5'd15, 16'd3};
        imem[4] = enc_i(6'd43, 0, 15, 44);
        imem[5] = enc_j(6'd2, 5);
        run(8);
        check("R11 undefined no write", dmem[11], 32'd12);
        check("R11 undefined falls through", imem_addr, BASE + 32'd20);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule